// File: doc/BRIEF.md
# Ordering Table Clear Engine

This engine prepares an empty ordering table in main memory for a display list builder. Software hands it a top address, an entry count and a control word, then pulses `start`. For one specific control value the engine walks downward from the word-aligned top address and writes one word per entry. Each word holds the 24-bit address of the word directly beneath it, so the table forms a chain that is followed from the top downward. The lowest entry holds an all-ones 24-bit terminator instead of a link.

The walk is cut short so that nothing is written at or below the configured base of main memory. Any other control value is rejected: the channel finishes at once, with no memory traffic. In every case the engine finishes by clearing the start and enable bits of its control word (bits 28 and 24) and raising a one-cycle interrupt pulse. Memory writes leave through a simple valid/ready port, at most one word per cycle.

Top module: `otc_clear`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o`, `irq_o` and `wr_valid_o` are low and `chcr_o` reads zero.
- R2: A `start` pulse is taken only when the engine is idle. A `start` pulse during a job changes neither the write sequence nor the completion of that job.
- R3: A control word other than 0x11000002 causes no memory write. It still produces exactly one interrupt pulse, and `chcr_o` then shows the control word with bits 24 and 28 cleared.
- R4: The top address is word aligned by forcing bits 1:0 to zero, and the first write goes to that aligned address.
- R5: Entry k (k = 0, 1, ...) is written to the aligned address minus 4k. Every entry except the last holds (its own address − 4) masked to the low 24 bits, with the upper 8 bits zero.
- R6: The number of entries written equals the count input. A count of zero writes nothing.
- R7: No write goes to an address at or below `MEM_BASE`. With top address A > `MEM_BASE`, at most (A − `MEM_BASE`)/4 entries are written. With A ≤ `MEM_BASE`, no entries are written.
- R8: The last entry written holds the terminator 0x00FFFFFF.
- R9: A write request, once raised, keeps the same address and data until `wr_ready_i` accepts it. At most one word is accepted per cycle.
- R10: `irq_o` is high for exactly one cycle, in the cycle after the final write is accepted (or the cycle after `start` when there are no writes). `busy_o` is low in the following cycle. With `wr_ready_i` held high, the pulse is visible n+1 cycles after the `start` edge for n entries.
- R11: During the interrupt cycle and afterwards, `chcr_o` equals the accepted control word with bits 24 and 28 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, sampled while idle |
| madr_i | input | 32 | Top address of the table (byte address) |
| bcr_i | input | CNT_W | Number of entries to write |
| chcr_i | input | 32 | Channel control word |
| busy_o | output | 1 | Job in progress, including the interrupt cycle |
| irq_o | output | 1 | One-cycle completion pulse |
| chcr_o | output | 32 | Live control word, with bits 24 and 28 cleared on completion |
| wr_valid_o | output | 1 | Memory write request |
| wr_addr_o | output | 32 | Memory write byte address |
| wr_data_o | output | 32 | Memory write data |
| wr_ready_i | input | 1 | Memory accepts the write in this cycle |

## Verification
The assertions check the rules that hold on every cycle:
- the reset state;
- requests held steady under back-pressure;
- word alignment and addresses strictly above the base;
- a 4-byte downward step between accepted writes;
- a single-cycle interrupt that finds the two control bits already cleared.

Only the bench scenarios can show the whole-job properties: the exact number of entries, the link value in each word, and the terminator in the last entry. The same holds for clamping at the base, rejection of foreign control words, `start` being ignored while busy, and the n+1 cycle latency. The bench sweeps aligned and unaligned top addresses around the base against every small count, under both steady and irregular ready patterns.

// File: rtl/otc_pkg.sv
package otc_pkg;

    // control word that launches a table clear
    localparam logic [31:0] OTC_RUN_CODE = 32'h1100_0002;
    // bits dropped from the control word when a job ends
    localparam logic [31:0] OTC_DONE_CLR = 32'h1100_0000;
    // links are kept to 24 bits
    localparam int          OTC_PTR_W    = 24;
    localparam logic [31:0] OTC_PTR_MASK = (32'h1 << OTC_PTR_W) - 32'h1;
    // end-of-chain word
    localparam logic [31:0] OTC_TERM     = OTC_PTR_MASK;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } otc_state_e;

    typedef struct packed {
        logic        cmd_ok;   // control word matched
        logic [31:0] addr;     // aligned top address
        logic [31:0] count;    // entries that will be written
    } otc_job_t;

    function automatic logic [31:0] otc_align(input logic [31:0] a);
        return {a[31:2], 2'b00};
    endfunction

    function automatic logic [31:0] otc_link(input logic [31:0] a);
        return (a - 32'd4) & OTC_PTR_MASK;
    endfunction

    // entries that fit strictly above the memory base
    function automatic logic [31:0] otc_room(input logic [31:0] a, input logic [31:0] base);
        if (a > base) return (a - base) >> 2;
        return 32'd0;
    endfunction

endpackage

// File: rtl/otc_cmd_decode.sv
module otc_cmd_decode
    import otc_pkg::*;
#(
    parameter int          CNT_W    = 16,
    parameter logic [31:0] MEM_BASE = 32'h0
) (
    input  logic [31:0]      madr_i,
    input  logic [CNT_W-1:0] bcr_i,
    input  logic [31:0]      chcr_i,
    output otc_job_t         job_o
);

    logic [31:0] aligned;
    logic [31:0] room;
    logic [31:0] want;
    logic        cmd_ok;

    always_comb begin
        aligned = otc_align(madr_i);
        room    = otc_room(aligned, MEM_BASE);
        want    = 32'(bcr_i);
        cmd_ok  = (chcr_i == OTC_RUN_CODE);

        job_o.cmd_ok = cmd_ok;
        job_o.addr   = aligned;
        if (!cmd_ok)
            job_o.count = 32'd0;
        else if (want < room)
            job_o.count = want;
        else
            job_o.count = room;
    end

endmodule

// File: rtl/otc_walker.sv
module otc_walker
    import otc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [31:0]      load_addr,
    input  logic [CNT_W-1:0] load_count,
    input  logic             step,
    output logic [31:0]      cur_addr,
    output logic [31:0]      cur_data,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [31:0]      addr_q;
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= 32'd0;
            remain_q <= '0;
        end else if (load) begin
            addr_q   <= load_addr;
            remain_q <= load_count;
        end else if (step) begin
            addr_q   <= addr_q - 32'd4;
            remain_q <= remain_q - ONE;
        end
    end

    always_comb begin
        last     = (remain_q == ONE);
        cur_addr = addr_q;
        cur_data = last ? OTC_TERM : otc_link(addr_q);
    end

endmodule

// File: rtl/otc_seq.sv
module otc_seq
    import otc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic has_work,
    input  logic last,
    input  logic wr_ready,
    output logic load,
    output logic step,
    output logic finish_now,
    output logic busy,
    output logic irq,
    output logic wr_valid
);

    otc_state_e state_q, state_d;

    always_comb begin
        state_d    = state_q;
        load       = 1'b0;
        finish_now = 1'b0;
        wr_valid   = (state_q == ST_RUN);
        step       = wr_valid && wr_ready;
        irq        = (state_q == ST_FINISH);
        busy       = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (has_work) begin
                        state_d = ST_RUN;
                    end else begin
                        state_d    = ST_FINISH;
                        finish_now = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (step && last) begin
                    state_d    = ST_FINISH;
                    finish_now = 1'b1;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/otc_clear.sv
module otc_clear
    import otc_pkg::*;
#(
    parameter int          CNT_W    = 16,
    parameter logic [31:0] MEM_BASE = 32'h0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [31:0]      madr_i,
    input  logic [CNT_W-1:0] bcr_i,
    input  logic [31:0]      chcr_i,
    output logic             busy_o,
    output logic             irq_o,
    output logic [31:0]      chcr_o,
    output logic             wr_valid_o,
    output logic [31:0]      wr_addr_o,
    output logic [31:0]      wr_data_o,
    input  logic             wr_ready_i
);

    otc_job_t    job;
    logic        load, step, finish_now, last;
    logic [31:0] ctl_q;

    otc_cmd_decode #(.CNT_W(CNT_W), .MEM_BASE(MEM_BASE)) u_dec (
        .madr_i (madr_i),
        .bcr_i  (bcr_i),
        .chcr_i (chcr_i),
        .job_o  (job)
    );

    otc_walker #(.CNT_W(CNT_W)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_addr  (job.addr),
        .load_count (job.count[CNT_W-1:0]),
        .step       (step),
        .cur_addr   (wr_addr_o),
        .cur_data   (wr_data_o),
        .last       (last)
    );

    otc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .has_work   (job.count != 32'd0),
        .last       (last),
        .wr_ready   (wr_ready_i),
        .load       (load),
        .step       (step),
        .finish_now (finish_now),
        .busy       (busy_o),
        .irq        (irq_o),
        .wr_valid   (wr_valid_o)
    );

    // live control word; the run bits drop as the job ends
    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= 32'd0;
        else if (load && finish_now)
            ctl_q <= chcr_i & ~OTC_DONE_CLR;
        else if (load)
            ctl_q <= chcr_i;
        else if (finish_now)
            ctl_q <= ctl_q & ~OTC_DONE_CLR;
    end

    assign chcr_o = ctl_q;

endmodule

// File: rtl/otc_clear_chk.sv
module otc_clear_chk #(
    parameter logic [31:0] MEM_BASE = 32'h0
) (
    input logic        clk,
    input logic        rst,
    input logic        busy_o,
    input logic        irq_o,
    input logic [31:0] chcr_o,
    input logic        wr_valid_o,
    input logic [31:0] wr_addr_o,
    input logic [31:0] wr_data_o,
    input logic        wr_ready_i
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy_o && !irq_o && !wr_valid_o && chcr_o == 32'd0));

    // R9
    hold_request_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && !wr_ready_i) |=>
            (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    // R4
    aligned_addr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |-> (wr_addr_o[1:0] == 2'b00));

    // R7
    above_base_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |-> (wr_addr_o > MEM_BASE));

    // R5
    descend_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && wr_ready_i) |=>
            (!wr_valid_o || wr_addr_o == $past(wr_addr_o) - 32'd4));

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> (!irq_o && !busy_o));

    // R10
    irq_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (busy_o && !wr_valid_o));

    // R11
    irq_ctl_clear_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((chcr_o & 32'h1100_0000) == 32'd0));

endmodule

bind otc_clear otc_clear_chk #(.MEM_BASE(MEM_BASE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_o     (busy_o),
    .irq_o      (irq_o),
    .chcr_o     (chcr_o),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .wr_ready_i (wr_ready_i)
);

// File: tb/otc_clear_tb.sv
module otc_clear_tb;

    localparam int          CNT_W = 8;
    localparam logic [31:0] BASE  = 32'h40;
    localparam logic [31:0] RUN   = 32'h1100_0002;
    localparam logic [31:0] CLR   = 32'h1100_0000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [31:0]      madr = 32'd0;
    logic [CNT_W-1:0] bcr = '0;
    logic [31:0]      chcr = 32'd0;
    logic             wr_ready = 1'b0;
    logic             busy, irq, wr_valid;
    logic [31:0]      chcr_o, wr_addr, wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    otc_clear #(.CNT_W(CNT_W), .MEM_BASE(BASE)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .madr_i     (madr),
        .bcr_i      (bcr),
        .chcr_i     (chcr),
        .busy_o     (busy),
        .irq_o      (irq),
        .chcr_o     (chcr_o),
        .wr_valid_o (wr_valid),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .wr_ready_i (wr_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit ready_at(input int mode, input int t);
        if (mode == 0) return 1'b1;
        return ((t * 7) % 5) > 1;
    endfunction

    task automatic run_job(input logic [31:0] m, input int b, input logic [31:0] c,
                           input int mode, input bit poke);
        logic [31:0] a;
        int exp_n, room, got_n, lat;
        bit irq_seen;
        a = m & ~32'd3;
        room  = (a > BASE) ? int'((a - BASE) >> 2) : 0;
        exp_n = (c != RUN) ? 0 : ((b < room) ? b : room);
        @(negedge clk);
        madr = m; bcr = CNT_W'(b); chcr = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_n = 0; lat = 0; irq_seen = 1'b0;
        for (int t = 1; t < 400 && !irq_seen; t++) begin
            wr_ready = ready_at(mode, t);
            if (poke && t == 2) begin
                // R2: foreign launch while busy
                start = 1'b1; madr = 32'h3F0; bcr = CNT_W'(5); chcr = RUN;
            end else begin
                start = 1'b0;
            end
            if (wr_valid && wr_ready) begin
                check(got_n < exp_n, "R6", "extra write", 32'(got_n), 32'(exp_n));
                check(wr_addr == a - 32'(4 * got_n), "R5", "write address",
                      wr_addr, a - 32'(4 * got_n));
                if (got_n == exp_n - 1)
                    check(wr_data == 32'h00FF_FFFF, "R8", "terminator", wr_data, 32'h00FF_FFFF);
                else
                    check(wr_data == ((a - 32'(4 * got_n) - 32'd4) & 32'h00FF_FFFF), "R5",
                          "link value", wr_data, (a - 32'(4 * got_n) - 32'd4) & 32'h00FF_FFFF);
                got_n++;
            end
            if (irq) begin
                irq_seen = 1'b1;
                lat = t;
                check(chcr_o == (c & ~CLR), "R11", "control on completion", chcr_o, c & ~CLR);
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(irq_seen, "R10", "interrupt raised", 32'(irq_seen), 32'd1);
        check(got_n == exp_n, (c != RUN) ? "R3" : "R6", "entries written",
              32'(got_n), 32'(exp_n));
        if (mode == 0)
            check(lat == exp_n + 1, "R10", "latency", 32'(lat), 32'(exp_n + 1));
        check(!irq && !busy && !wr_valid, "R10", "single pulse then idle",
              {29'd0, irq, busy, wr_valid}, 32'd0);
        if (poke)
            check(!busy, "R2", "ignored launch did not start a job", 32'(busy), 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !irq && !wr_valid, "R1", "outputs in reset",
              {29'd0, busy, irq, wr_valid}, 32'd0);
        check(chcr_o == 32'd0, "R1", "control in reset", chcr_o, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !irq && !wr_valid, "R1", "outputs after reset",
              {29'd0, busy, irq, wr_valid}, 32'd0);

        // R4 R6 R7: sweep top address (aligned and not) around base, every small count
        for (int mode = 0; mode < 2; mode++)
            for (int off = -8; off <= 44; off++)
                for (int b = 0; b <= 12; b++)
                    run_job(BASE + 32'(off), b, RUN, mode, 1'b0);

        // R7: count far larger than room
        run_job(BASE + 32'h20, 255, RUN, 0, 1'b0);
        run_job(BASE + 32'h23, 255, RUN, 1, 1'b0);
        // R5: upper address bits masked out of the links
        run_job(32'h8100_0010, 3, RUN, 0, 1'b0);
        run_job(32'hFFFF_FF1E, 6, RUN, 1, 1'b0);
        // R3: foreign control words
        run_job(32'h100, 4, 32'h0100_0002, 0, 1'b0);
        run_job(32'h100, 4, 32'h1100_0003, 0, 1'b0);
        run_job(32'h100, 4, 32'h0000_0000, 1, 1'b0);
        run_job(32'h100, 4, 32'hFFFF_FFFF, 0, 1'b0);
        // R2: launch while busy ignored
        run_job(32'h200, 9, RUN, 0, 1'b1);
        run_job(32'h200, 9, RUN, 1, 1'b1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule